// File: doc/BRIEF.md
# Two-Dimensional Strided Transfer Engine

This engine sits beside a core's scratchpad and moves data by itself once software hands it a descriptor and a start strobe. The core keeps running while the engine walks its pattern. Each request it issues names one 16-byte beat: a source address and a destination address. The data path, address translation and coherence all lie outside the block.

The source side follows a two-level pattern. A chunk is a run of contiguous beats. Chunks are spaced by a chunk stride, which is measured in bytes from the start of one chunk to the start of the next. A fixed number of chunks forms a block, and blocks are spaced by a block stride, measured from block start to block start. The destination side is packed: each beat lands 16 bytes after the previous one.

A path bit in the descriptor selects the port that carries the requests. One port faces the shared cache and memory side. The other faces the router, for a peer scratchpad. A congestion input from the network holds issue back. Completion raises a sticky done flag and a one-cycle pulse. A start that arrives while the engine is busy is dropped and reported.

Top module: `stride_mover`

## Requirements
- R1: After reset, busy_o, done_o, cpl_o, start_err_o, mem_valid_o and net_valid_o are all 0.
- R2: A start_i sampled while idle, with beats, chunks and blocks all nonzero, sets busy_o and clears done_o on the next cycle. The first request then carries src_base_i and dst_base_i.
- R3: The source address rises by 16 inside a chunk. A new chunk starts at the previous chunk's start plus chunk_stride_i. A new block starts at the previous block's start plus block_stride_i.
- R4: The destination address rises by 16 on every accepted beat, starting at dst_base_i.
- R5: With path bit dir_i = 0, requests use only mem_valid_o. With dir_i = 1, they use only net_valid_o. The two valids are never high together.
- R6: At most one beat is accepted per cycle. While a request is not accepted, req_src_o and req_dst_o hold their values and the valid stays high (congestion aside).
- R7: In any cycle with congest_i high, both valids are low in that same cycle.
- R8: Exactly beats x chunks x blocks requests are accepted. The cycle after the last one is accepted, busy_o is 0, done_o is 1, and cpl_o is high for exactly one cycle.
- R9: A start_i sampled while busy raises start_err_o for one cycle on the next cycle. It leaves the running transfer's addresses, path and length unchanged.
- R10: A start with beats, chunks or blocks equal to zero sets done_o and pulses cpl_o on the next cycle, never sets busy_o, and issues no request.
- R11: done_o stays high until the next start that is accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for the descriptor on the inputs below |
| dir_i | input | 1 | Path select: 0 memory side, 1 router side |
| src_base_i | input | AW | Source base byte address |
| dst_base_i | input | AW | Destination base byte address |
| beats_i | input | LENW | Beats per chunk |
| chunks_i | input | CNTW | Chunks per block |
| chunk_stride_i | input | AW | Chunk start-to-start distance in bytes |
| blocks_i | input | CNTW | Number of blocks |
| block_stride_i | input | AW | Block start-to-start distance in bytes |
| congest_i | input | 1 | Network load high: hold issue |
| mem_valid_o | output | 1 | Request valid toward the memory side |
| mem_ready_i | input | 1 | Memory side accepts the request |
| net_valid_o | output | 1 | Request valid toward the router |
| net_ready_i | input | 1 | Router accepts the request |
| req_src_o | output | AW | Source address of the current beat |
| req_dst_o | output | AW | Destination address of the current beat |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky completion flag |
| cpl_o | output | 1 | One-cycle completion pulse |
| start_err_o | output | 1 | One-cycle pulse: start ignored while busy |

## Verification
A wrong beat, chunk or block counter shows up on the very next accepted request as a source address that breaks the stride pattern. Because the scoreboard compares every beat, the error is caught at that beat. A bad final-beat decision shows within one cycle of the last accepted request, as a missing or extra request, or a cpl_o pulse out of place. Corruption from an ignored start shows on the following beat as a changed address or a changed port.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int unsigned BEAT_BYTES = 16;

  typedef enum logic {
    PATH_MEM = 1'b0,
    PATH_NET = 1'b1
  } path_e;
endpackage

// File: rtl/stm_walk.sv
module stm_walk
  import stm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 8,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [AW-1:0]   src_base_i,
  input  logic [AW-1:0]   dst_base_i,
  input  logic [LENW-1:0] beats_i,
  input  logic [CNTW-1:0] chunks_i,
  input  logic [CNTW-1:0] blocks_i,
  input  logic [AW-1:0]   chunk_stride_i,
  input  logic [AW-1:0]   block_stride_i,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   dst_o,
  output logic            last_o
);
  localparam logic [AW-1:0]   BEAT_A = AW'(BEAT_BYTES);
  localparam logic [LENW-1:0] ONE_L  = LENW'(1);
  localparam logic [CNTW-1:0] ONE_C  = CNTW'(1);

  logic [LENW-1:0] beat_q, beat_d, len_q;
  logic [CNTW-1:0] chk_q, chk_d, blk_q, blk_d, cpb_q, nblk_q;
  logic [AW-1:0]   src_q, src_d, dst_q, dst_d;
  logic [AW-1:0]   cbase_q, cbase_d, bbase_q, bbase_d;
  logic [AW-1:0]   cstr_q, bstr_q;
  logic            chunk_end, block_end;

  assign chunk_end = (beat_q + ONE_L) == len_q;
  assign block_end = chunk_end && ((chk_q + ONE_C) == cpb_q);
  assign last_o    = block_end && ((blk_q + ONE_C) == nblk_q);
  assign src_o     = src_q;
  assign dst_o     = dst_q;

  always_comb begin
    beat_d  = beat_q;
    chk_d   = chk_q;
    blk_d   = blk_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cbase_d = cbase_q;
    bbase_d = bbase_q;
    if (load_i) begin
      beat_d  = '0;
      chk_d   = '0;
      blk_d   = '0;
      src_d   = src_base_i;
      dst_d   = dst_base_i;
      cbase_d = src_base_i;
      bbase_d = src_base_i;
    end else if (step_i) begin
      dst_d = dst_q + BEAT_A;
      if (!chunk_end) begin
        beat_d = beat_q + ONE_L;
        src_d  = src_q + BEAT_A;
      end else if (!block_end) begin
        beat_d  = '0;
        chk_d   = chk_q + ONE_C;
        cbase_d = cbase_q + cstr_q;
        src_d   = cbase_q + cstr_q;
      end else begin
        beat_d  = '0;
        chk_d   = '0;
        blk_d   = blk_q + ONE_C;
        bbase_d = bbase_q + bstr_q;
        cbase_d = bbase_q + bstr_q;
        src_d   = bbase_q + bstr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      chk_q   <= '0;
      blk_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cbase_q <= '0;
      bbase_q <= '0;
    end else if (load_i || step_i) begin
      beat_q  <= beat_d;
      chk_q   <= chk_d;
      blk_q   <= blk_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cbase_q <= cbase_d;
      bbase_q <= bbase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      cpb_q  <= '0;
      nblk_q <= '0;
      cstr_q <= '0;
      bstr_q <= '0;
    end else if (load_i) begin
      len_q  <= beats_i;
      cpb_q  <= chunks_i;
      nblk_q <= blocks_i;
      cstr_q <= chunk_stride_i;
      bstr_q <= block_stride_i;
    end
  end

  // R4: destination is packed, one beat further per accepted request
  assert_packed_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> dst_o == $past(dst_o) + BEAT_A);

  // R3: inside a chunk the source moves by one beat
  assert_chunk_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !chunk_end) |=> src_o == $past(src_o) + BEAT_A);
endmodule

// File: rtl/stm_port.sv
module stm_port
  import stm_pkg::*;
(
  input  logic  req_i,
  input  path_e path_i,
  input  logic  congest_i,
  input  logic  mem_ready_i,
  input  logic  net_ready_i,
  output logic  mem_valid_o,
  output logic  net_valid_o,
  output logic  fire_o
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] rdy, vld;

  assign rdy = {net_ready_i, mem_ready_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign vld[p] = req_i && !congest_i && (int'(path_i) == p);
  end

  assign mem_valid_o = vld[0];
  assign net_valid_o = vld[1];
  assign fire_o      = |(vld & rdy);
endmodule

// File: rtl/stride_mover.sv
module stride_mover
  import stm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 8,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_i,
  input  logic [AW-1:0]   src_base_i,
  input  logic [AW-1:0]   dst_base_i,
  input  logic [LENW-1:0] beats_i,
  input  logic [CNTW-1:0] chunks_i,
  input  logic [AW-1:0]   chunk_stride_i,
  input  logic [CNTW-1:0] blocks_i,
  input  logic [AW-1:0]   block_stride_i,
  input  logic            congest_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic            net_valid_o,
  input  logic            net_ready_i,
  output logic [AW-1:0]   req_src_o,
  output logic [AW-1:0]   req_dst_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            cpl_o,
  output logic            start_err_o
);
  logic  busy_q, busy_d, done_q, done_d, cpl_q, cpl_d, err_q, err_d;
  path_e path_q, path_d;
  logic  start_ok, empty_job, load, fire, last, finish;

  assign start_ok  = start_i && !busy_q;
  assign empty_job = (beats_i == '0) || (chunks_i == '0) || (blocks_i == '0);
  assign load      = start_ok && !empty_job;
  assign finish    = busy_q && fire && last;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    path_d = path_q;
    if (start_ok) begin
      busy_d = !empty_job;
      done_d = empty_job;
      path_d = path_e'(dir_i);
    end else if (finish) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
    cpl_d = (start_ok && empty_job) || finish;
    err_d = start_i && busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cpl_q  <= 1'b0;
      err_q  <= 1'b0;
      path_q <= PATH_MEM;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cpl_q  <= cpl_d;
      err_q  <= err_d;
      path_q <= path_d;
    end
  end

  stm_walk #(.AW(AW), .LENW(LENW), .CNTW(CNTW)) i_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_i         (load),
    .step_i         (busy_q && fire),
    .src_base_i     (src_base_i),
    .dst_base_i     (dst_base_i),
    .beats_i        (beats_i),
    .chunks_i       (chunks_i),
    .blocks_i       (blocks_i),
    .chunk_stride_i (chunk_stride_i),
    .block_stride_i (block_stride_i),
    .src_o          (req_src_o),
    .dst_o          (req_dst_o),
    .last_o         (last)
  );

  stm_port i_port (
    .req_i       (busy_q),
    .path_i      (path_q),
    .congest_i   (congest_i),
    .mem_ready_i (mem_ready_i),
    .net_ready_i (net_ready_i),
    .mem_valid_o (mem_valid_o),
    .net_valid_o (net_valid_o),
    .fire_o      (fire)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign cpl_o       = cpl_q;
  assign start_err_o = err_q;

  assert_one_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid_o && net_valid_o));

  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fire) |=> $stable(req_src_o) && $stable(req_dst_o));

  assert_congest_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    congest_i |-> !(mem_valid_o || net_valid_o));

  assert_cpl_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_o |=> !cpl_o);

  assert_err_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_err_o |-> $past(busy_o));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(mem_valid_o || net_valid_o));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

// File: tb/test_stride_mover.sv
module test_stride_mover;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, dir_i = 1'b0;
  logic [AW-1:0] src_base_i = '0, dst_base_i = '0;
  logic [7:0]    beats_i = '0, chunks_i = '0, blocks_i = '0;
  logic [AW-1:0] chunk_stride_i = '0, block_stride_i = '0;
  logic          congest_i = 1'b0, mem_ready_i = 1'b0, net_ready_i = 1'b0;
  logic          mem_valid_o, net_valid_o, busy_o, done_o, cpl_o, start_err_o;
  logic [AW-1:0] req_src_o, req_dst_o;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  int cpl_cnt = 0;
  logic [7:0] lfsr = 8'hA5;
  logic expect_cpl = 1'b0;
  logic [64:0] expq[$];

  always #10 clk = ~clk;

  stride_mover i_stride_mover (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .src_base_i(src_base_i), .dst_base_i(dst_base_i), .beats_i(beats_i),
    .chunks_i(chunks_i), .chunk_stride_i(chunk_stride_i), .blocks_i(blocks_i),
    .block_stride_i(block_stride_i), .congest_i(congest_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .net_valid_o(net_valid_o), .net_ready_i(net_ready_i),
    .req_src_o(req_src_o), .req_dst_o(req_dst_o), .busy_o(busy_o),
    .done_o(done_o), .cpl_o(cpl_o), .start_err_o(start_err_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // handshake stimulus, changed shortly after each rising edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (mode)
      1: begin mem_ready_i = lfsr[0]; net_ready_i = lfsr[1]; congest_i = lfsr[2] & lfsr[3]; end
      2: begin mem_ready_i = 1'b1; net_ready_i = 1'b1; congest_i = 1'b1; end
      3: begin mem_ready_i = 1'b0; net_ready_i = 1'b0; congest_i = 1'b0; end
      default: begin mem_ready_i = 1'b1; net_ready_i = 1'b1; congest_i = 1'b0; end
    endcase
  end

  // monitor: pops the scoreboard on every accepted request
  always @(negedge clk) begin
    if (rst_n) begin
      if (expect_cpl) begin
        chk(cpl_o && done_o && !busy_o, "R8 completion after last beat",
            {cpl_o, done_o, busy_o}, 3'b110);
        expect_cpl = 1'b0;
      end
      if (cpl_o) cpl_cnt++;
      if ((mem_valid_o && mem_ready_i) || (net_valid_o && net_ready_i)) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R10/R8 unexpected request", {req_src_o, req_dst_o}, 0);
        end else begin
          logic [64:0] e;
          e = expq.pop_front();
          chk(req_src_o == e[63:32], "R3 source address", req_src_o, e[63:32]);
          chk(req_dst_o == e[31:0], "R4 destination address", req_dst_o, e[31:0]);
          chk(net_valid_o == e[64] && mem_valid_o == !e[64], "R5 port select",
              {mem_valid_o, net_valid_o}, {!e[64], e[64]});
          if (expq.size() == 0) expect_cpl = 1'b1;
        end
      end
    end
  end

  task automatic push_expect(input logic d, input logic [AW-1:0] s, input logic [AW-1:0] t,
                             input int nb, input int nc, input logic [AW-1:0] cs,
                             input int nk, input logic [AW-1:0] bs);
    logic [AW-1:0] dst;
    dst = t;
    for (int k = 0; k < nk; k++)
      for (int c = 0; c < nc; c++)
        for (int b = 0; b < nb; b++) begin
          expq.push_back({d, s + AW'(k) * bs + AW'(c) * cs + AW'(b * 16), dst});
          dst = dst + 32'd16;
        end
  endtask

  task automatic launch(input logic d, input logic [AW-1:0] s, input logic [AW-1:0] t,
                        input int nb, input int nc, input logic [AW-1:0] cs,
                        input int nk, input logic [AW-1:0] bs);
    @(posedge clk); #1;
    dir_i = d; src_base_i = s; dst_base_i = t; beats_i = 8'(nb); chunks_i = 8'(nc);
    chunk_stride_i = cs; blocks_i = 8'(nk); block_stride_i = bs; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    while (busy_o && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(!busy_o && done_o && expq.size() == 0, tag, {busy_o, done_o}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    logic [AW-1:0] hs;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !cpl_o && !start_err_o && !mem_valid_o && !net_valid_o,
        "R1 reset state", {busy_o, done_o, cpl_o, start_err_o, mem_valid_o, net_valid_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // A: memory path, 2 beats x 3 chunks x 2 blocks under stalls
    push_expect(1'b0, 32'h1000, 32'h8000, 2, 3, 32'h40, 2, 32'h400);
    c0 = cpl_cnt;
    mode = 3;
    launch(1'b0, 32'h1000, 32'h8000, 2, 3, 32'h40, 2, 32'h400);
    @(negedge clk);
    chk(busy_o && !done_o, "R2 busy after start", {busy_o, done_o}, 2'b10);
    chk(mem_valid_o && req_src_o == 32'h1000 && req_dst_o == 32'h8000,
        "R2 first request", req_src_o, 32'h1000);
    hs = req_src_o;
    @(negedge clk);
    chk(mem_valid_o && req_src_o == hs, "R6 held while not ready", req_src_o, hs);
    mode = 2;
    repeat (2) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(!mem_valid_o && !net_valid_o, "R7 congestion holds issue",
          {mem_valid_o, net_valid_o}, 0);
    end
    mode = 1;
    wait_idle("R8 transfer A finished");
    chk(cpl_cnt == c0 + 1, "R8 single completion pulse", cpl_cnt - c0, 1);
    repeat (4) @(negedge clk);
    chk(done_o, "R11 done stays set", done_o, 1);

    // B: router path, ignored start midway
    mode = 0;
    push_expect(1'b1, 32'h2000, 32'h9000, 1, 2, 32'h100, 3, 32'h1000);
    launch(1'b1, 32'h2000, 32'h9000, 1, 2, 32'h100, 3, 32'h1000);
    @(negedge clk);
    chk(!done_o, "R11 done cleared by new start", done_o, 0);
    mode = 3;
    @(posedge clk); #1;
    dir_i = 1'b0; src_base_i = 32'h5555_0000; beats_i = 8'd9; start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    @(negedge clk);
    chk(start_err_o && busy_o, "R9 start while busy flagged", {start_err_o, busy_o}, 2'b11);
    @(negedge clk);
    chk(!start_err_o, "R9 error is a pulse", start_err_o, 0);
    mode = 1;
    wait_idle("R9 transfer B unchanged by ignored start");

    // C: zero-length descriptors
    mode = 0;
    for (int z = 0; z < 3; z++) begin
      c0 = cpl_cnt;
      launch(1'b0, 32'h3000, 32'hA000, (z == 0) ? 0 : 2, (z == 1) ? 0 : 2, 32'h40,
             (z == 2) ? 0 : 2, 32'h400);
      @(negedge clk);
      chk(done_o && cpl_o && !busy_o, "R10 empty job completes at once",
          {done_o, cpl_o, busy_o}, 3'b110);
      repeat (3) @(negedge clk);
      chk(!busy_o && cpl_cnt == c0 + 1, "R10 no traffic", cpl_cnt - c0, 1);
    end

    // D: single beat on the memory path
    push_expect(1'b0, 32'h40, 32'h80, 1, 1, 32'h0, 1, 32'h0);
    launch(1'b0, 32'h40, 32'h80, 1, 1, 32'h0, 1, 32'h0);
    wait_idle("R8 single beat transfer");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule